// File: doc/BRIEF.md
# Configurable ratio sample-stream demultiplexer

This block takes a fast stream of 10-bit samples, each with one side-band bit such as an overflow flag, and spreads consecutive samples across four parallel output ports (A, B, C, D). Each port then runs at a half or a quarter of the input rate. In 1:4 operation the samples go to A, B, C and D in turn. In 1:2 operation only A and B are used. The side-band bit always travels with its own sample.

The block runs in one system clock domain. The source clock `src_clk` is oversampled there as a data line. It captures on its rising transitions only, or on both transitions when the source clock runs at half the sample rate. The data-ready output marks each completed group, either as a one-cycle high pulse or as a level that toggles once per group. In simultaneous alignment, all active ports load together when a group completes. In staggered alignment, each port loads as soon as its own sample arrives, and the side-band position of that port is reused as that port's own strobe.

An asynchronous active-low reset sets the sample-to-port phase. The four mode pins are latched on the first clock edge after reset is released, and the block keeps its alignment from then on without any further reset.

Top module: `sample_fanout_dmux`

## Requirements
- R1: While reset is asserted, and until the first group of samples completes, every bit of `out_data`, `out_aux` and `data_rdy` is 0. The first sample captured after reset always belongs to port A.
- R2: With `sel_quad`=1, consecutive captured samples go to ports A, B, C and D in turn, then wrap back to A.
- R3: With `sel_quad`=0, samples alternate between ports A and B. Ports C and D keep their value of 0.
- R4: With `sel_dual_in`=0, only 0-to-1 transitions of `src_clk` capture `{din_side, din}`. A 1-to-0 transition, and any data present at that time, has no effect.
- R5: With `sel_dual_in`=1, every transition of `src_clk` captures one sample.
- R6: With `sel_stagger`=0, all active ports load together one clock after the last sample of a group is captured. They then hold their values until the next group completes.
- R7: With `sel_dual_out`=0, `data_rdy` is high for exactly the one clock in which a completed group first appears, and is low at all other times.
- R8: With `sel_dual_out`=1, `data_rdy` toggles once for each completed group.
- R9: With `sel_stagger`=1, each port loads its own sample one clock after that sample is captured. Successive ports therefore update one input sample apart.
- R10: With `sel_stagger`=1, `out_aux[k]` carries the strobe of port k: a one-cycle pulse when `sel_dual_out`=0, or a level that toggles per update when `sel_dual_out`=1. With `sel_stagger`=0, `out_aux[k]` carries the side-band bit of the sample held in port k.
- R11: `sel_quad`, `sel_dual_in`, `sel_dual_out` and `sel_stagger` are sampled only on the first clock edge after reset is released. Later changes have no effect until the next reset.
- R12: Port k (A=0 to D=3) appears on `out_data[10*k+9:10*k]`, with bit 0 as the LSB and bit 9 as the MSB. Its extra bit appears on `out_aux[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the source clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| src_clk | input | 1 | Source sample clock, observed as data |
| din | input | 10 | Incoming sample |
| din_side | input | 1 | Side-band bit travelling with the sample |
| sel_quad | input | 1 | 1: 1:4 ratio, 0: 1:2 ratio |
| sel_dual_in | input | 1 | 1: capture on both source clock transitions |
| sel_dual_out | input | 1 | 1: data_rdy and strobes toggle rather than pulse |
| sel_stagger | input | 1 | 1: staggered port updates with per-port strobes |
| out_data | output | 40 | Port A to D sample values, 10 bits each |
| out_aux | output | 4 | Per-port side-band bit or strobe |
| data_rdy | output | 1 | Group-complete marker |

## Verification
The hardest situation to reach is a change of a mode pin in the middle of a stream. It must leave the latched behaviour untouched until the next reset. The stimulus reaches this by flipping all four mode pins after a few samples of a run, while the bench model keeps predicting with the modes that were present at reset release. The falling-transition case of the single-edge mode is also deliberate: the bench changes the data on every falling source edge, so that a wrong capture would corrupt a visible port.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    // Mode selection latched after reset release
    typedef struct packed {
        logic quad;      // 1: four ports, 0: two ports
        logic dual_in;   // capture on both source clock transitions
        logic dual_out;  // toggle-style ready and strobes
        logic stagger;   // per-port staggered updates
    } dmx_cfg_t;

endpackage

// File: rtl/dmx_capture.sv
module dmx_capture
    import dmx_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_clk,
    input  logic [DW-1:0] din,
    input  logic          din_side,
    input  dmx_cfg_t      cfg_pins,
    output logic          cap_vld,
    output logic [DW:0]   cap_word,
    output dmx_cfg_t      cfg
);

    typedef struct packed {
        logic     armed;
        logic     prev;
        dmx_cfg_t cfg;
    } cap_st_t;

    cap_st_t s_d, s_q;
    logic    rise, fall;

    always_comb begin
        s_d       = s_q;
        s_d.prev  = src_clk;
        s_d.armed = 1'b1;
        if (!s_q.armed) begin
            s_d.cfg = cfg_pins;
        end
        rise     = src_clk & ~s_q.prev;
        fall     = ~src_clk & s_q.prev;
        cap_vld  = s_q.armed & (rise | (s_q.cfg.dual_in & fall));
        cap_word = {din_side, din};
        cfg      = s_q.cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Modes are frozen once the block is armed
    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.armed |=> $stable(s_q.cfg));

    // A falling source transition never captures in single-edge mode
    assert_fall_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.cfg.dual_in && !src_clk) |-> !cap_vld);

endmodule

// File: rtl/dmx_slot_ctrl.sv
module dmx_slot_ctrl
    import dmx_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_vld,
    input  dmx_cfg_t                 cfg,
    output logic [$clog2(LANES)-1:0] slot,
    output logic [$clog2(LANES):0]   n_active,
    output logic                     last
);

    localparam int SW = $clog2(LANES);

    typedef struct packed {
        logic [SW-1:0] slot;
    } slot_st_t;

    slot_st_t s_d, s_q;
    logic     at_end;

    always_comb begin
        s_d      = s_q;
        n_active = cfg.quad ? (SW+1)'(LANES) : (SW+1)'(LANES / 2);
        at_end   = ({1'b0, s_q.slot} == n_active - 1'b1);
        last     = cap_vld & at_end;
        if (cap_vld) begin
            s_d.slot = at_end ? '0 : s_q.slot + 1'b1;
        end
        slot = s_q.slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Slot pointer never leaves the active port range
    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, s_q.slot} < n_active) || !$stable(n_active));

    // Slot moves only on a capture
    assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_vld |=> $stable(s_q.slot));

endmodule

// File: rtl/dmx_lane.sv
module dmx_lane
    import dmx_pkg::*;
#(
    parameter int DW    = 10,
    parameter int LANES = 4,
    parameter int IDX   = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_vld,
    input  logic [DW:0]              cap_word,
    input  logic [$clog2(LANES)-1:0] slot,
    input  logic [$clog2(LANES):0]   n_active,
    input  logic                     last,
    input  dmx_cfg_t                 cfg,
    output logic [DW-1:0]            lane_data,
    output logic                     lane_aux
);

    localparam int SW = $clog2(LANES);
    localparam logic [SW-1:0] MY_SLOT = SW'(IDX);
    localparam logic [SW:0]   MY_POS  = (SW+1)'(IDX);

    typedef struct packed {
        logic [DW:0] stage;
        logic [DW:0] outw;
        logic        pulse;
        logic        tog;
    } lane_st_t;

    lane_st_t s_d, s_q;
    logic     mine, active, upd, strobe;

    always_comb begin
        s_d    = s_q;
        active = (MY_POS < n_active);
        mine   = cap_vld && (slot == MY_SLOT);
        upd    = cfg.stagger ? mine : (last & active);
        if (mine) begin
            s_d.stage = cap_word;
        end
        if (upd) begin
            s_d.outw = mine ? cap_word : s_q.stage;
        end
        s_d.pulse = upd;
        s_d.tog   = s_q.tog ^ upd;
        strobe    = cfg.dual_out ? s_q.tog : s_q.pulse;
        lane_data = s_q.outw[DW-1:0];
        lane_aux  = cfg.stagger ? strobe : s_q.outw[DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Unused ports in the 1:2 ratio never change
    assert_idle_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(s_q.outw));

    // Staggered: the port changes only after its own capture
    assert_own_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.stagger && !mine) |=> $stable(s_q.outw));

    // A pulse strobe lasts one clock
    assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |=> !s_q.pulse);

endmodule

// File: rtl/sample_fanout_dmux.sv
module sample_fanout_dmux
    import dmx_pkg::*;
#(
    parameter int DW    = 10,
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_clk,
    input  logic [DW-1:0]       din,
    input  logic                din_side,
    input  logic                sel_quad,
    input  logic                sel_dual_in,
    input  logic                sel_dual_out,
    input  logic                sel_stagger,
    output logic [LANES*DW-1:0] out_data,
    output logic [LANES-1:0]    out_aux,
    output logic                data_rdy
);

    localparam int SW = $clog2(LANES);

    typedef struct packed {
        logic pulse;
        logic tog;
    } rdy_st_t;

    dmx_cfg_t      cfg_pins, cfg;
    logic          cap_vld, last;
    logic [DW:0]   cap_word;
    logic [SW-1:0] slot;
    logic [SW:0]   n_active;
    rdy_st_t       s_d, s_q;

    assign cfg_pins = '{quad: sel_quad, dual_in: sel_dual_in,
                        dual_out: sel_dual_out, stagger: sel_stagger};

    dmx_capture #(.DW(DW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_clk  (src_clk),
        .din      (din),
        .din_side (din_side),
        .cfg_pins (cfg_pins),
        .cap_vld  (cap_vld),
        .cap_word (cap_word),
        .cfg      (cfg)
    );

    dmx_slot_ctrl #(.LANES(LANES)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_vld  (cap_vld),
        .cfg      (cfg),
        .slot     (slot),
        .n_active (n_active),
        .last     (last)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dmx_lane #(.DW(DW), .LANES(LANES), .IDX(k)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_vld   (cap_vld),
            .cap_word  (cap_word),
            .slot      (slot),
            .n_active  (n_active),
            .last      (last),
            .cfg       (cfg),
            .lane_data (out_data[k*DW +: DW]),
            .lane_aux  (out_aux[k])
        );
    end

    always_comb begin
        s_d       = s_q;
        s_d.pulse = last;
        s_d.tog   = s_q.tog ^ last;
        data_rdy  = cfg.dual_out ? s_q.tog : s_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Simultaneous: port data moves only together with a group marker
    assert_group_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.stagger && !$stable(out_data)) |-> s_q.pulse);

    // Ready pulse follows a capture
    assert_rdy_after_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |-> $past(cap_vld));

    // Toggle ready changes once per completed group
    assert_rdy_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.tog) |-> s_q.pulse);

endmodule

// File: tb/sim_sample_fanout_dmux.sv
module sim_sample_fanout_dmux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_clk = 1'b0;
    logic [9:0]  din = '0;
    logic        din_side = 1'b0;
    logic        sel_quad = 1'b0, sel_dual_in = 1'b0, sel_dual_out = 1'b0, sel_stagger = 1'b0;
    logic [39:0] out_data;
    logic [3:0]  out_aux;
    logic        data_rdy;

    int total = 0;
    int bad   = 0;

    // model state
    bit          m_quad, m_din2, m_dout2, m_stag;
    logic [10:0] m_stage [4];
    logic [10:0] m_out   [4];
    bit          m_pulse [4];
    bit          m_tog   [4];
    bit          m_drp, m_drt;
    int          m_slot;

    always #10 clk = ~clk;

    sample_fanout_dmux u0 (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .din(din), .din_side(din_side),
        .sel_quad(sel_quad), .sel_dual_in(sel_dual_in), .sel_dual_out(sel_dual_out),
        .sel_stagger(sel_stagger), .out_data(out_data), .out_aux(out_aux), .data_rdy(data_rdy)
    );

    task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int n_act();
        return m_quad ? 4 : 2;
    endfunction

    function automatic logic [39:0] exp_data();
        logic [39:0] v;
        for (int k = 0; k < 4; k++) v[k*10 +: 10] = m_out[k][9:0];
        return v;
    endfunction

    function automatic logic [3:0] exp_aux();
        logic [3:0] v;
        for (int k = 0; k < 4; k++)
            v[k] = m_stag ? (m_dout2 ? m_tog[k] : m_pulse[k]) : m_out[k][10];
        return v;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin
            m_stage[k] = '0; m_out[k] = '0; m_pulse[k] = 0; m_tog[k] = 0;
        end
        m_drp = 0; m_drt = 0; m_slot = 0;
    endtask

    task automatic model_clear();
        for (int k = 0; k < 4; k++) m_pulse[k] = 0;
        m_drp = 0;
    endtask

    task automatic model_apply(logic [10:0] w);
        int k;
        model_clear();
        k = m_slot;
        m_stage[k] = w;
        if (m_stag) begin
            m_out[k] = w; m_pulse[k] = 1; m_tog[k] ^= 1;
        end
        if (k == n_act() - 1) begin
            if (!m_stag) begin
                for (int j = 0; j < n_act(); j++) begin
                    m_out[j] = m_stage[j]; m_pulse[j] = 1; m_tog[j] ^= 1;
                end
            end
            m_drp = 1; m_drt ^= 1;
            m_slot = 0;
        end else begin
            m_slot = k + 1;
        end
    endtask

    task automatic check_all(string ovr);
        string td, ta, tr;
        logic [39:0] ed;
        ed = exp_data();
        td = (ovr != "") ? ovr : (m_stag ? "R9" : "R6");
        ta = (ovr != "") ? ovr : (m_stag ? "R10" : "R12");
        tr = (ovr != "") ? ovr : (m_dout2 ? "R8" : "R7");
        chk(td, out_data[19:0], ed[19:0]);
        chk((ovr != "") ? ovr : (m_quad ? td : "R3"), out_data[39:20], ed[39:20]);
        chk(ta, 40'(out_aux), 40'(exp_aux()));
        chk(tr, 40'(data_rdy), 40'(m_drt & m_dout2 | m_drp & !m_dout2));
    endtask

    task automatic run(bit q, bit di, bit dd, bit st, int ns, bit flip, bit directed);
        logic [10:0] w;
        @(negedge clk);
        rst_n = 1'b0; src_clk = 1'b0;
        sel_quad = q; sel_dual_in = di; sel_dual_out = dd; sel_stagger = st;
        m_quad = q; m_din2 = di; m_dout2 = dd; m_stag = st;
        model_reset();
        repeat (2) @(negedge clk);
        chk("R1", {out_data[35:0], out_aux}, '0);
        chk("R1", 40'(data_rdy), '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1");
        for (int i = 0; i < ns; i++) begin
            if (flip && i == 3) begin
                sel_quad = ~q; sel_dual_in = ~di; sel_dual_out = ~dd; sel_stagger = ~st;
            end
            w = directed ? {(i == 3), 10'(i + 1)} : 11'($urandom);
            din = w[9:0]; din_side = w[10];
            src_clk = m_din2 ? ~src_clk : 1'b1;
            @(negedge clk);
            model_apply(w);
            check_all(flip && i > 3 ? "R11" : (i == 0 && m_stag ? "R1" : ""));
            if (!m_din2) begin
                src_clk = 1'b0;
                w = 11'($urandom);
                din = w[9:0]; din_side = w[10];
                @(negedge clk);
                model_clear();
                check_all("R4");
            end else begin
                @(negedge clk);
                model_clear();
                check_all("R5");
            end
        end
    endtask

    initial begin
        void'($urandom(32'h1234_abcd));
        // directed order and field layout check, 1:4 simultaneous
        run(1, 0, 0, 0, 4, 0, 1);
        chk("R2", out_data, {10'd4, 10'd3, 10'd2, 10'd1});
        chk("R12", 40'(out_aux), 40'(4'b1000));
        // every mode combination with random samples
        for (int m = 0; m < 16; m++) begin
            run(m[0], m[1], m[2], m[3], 10, 0, 0);
        end
        // mode pins flipped mid-stream
        run(1, 1, 0, 1, 10, 1, 0);
        run(0, 0, 1, 0, 10, 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule